// File: doc/BRIEF.md
# Timer Compare Output Unit

A 16-bit timer/counter with two compare channels, A and B. The counter advances on ticks from a shared prescaler. It runs either freely from zero up to all ones and round again, or in clear-on-compare mode, where compare register A acts as its upper limit. Each channel compares the counter with its own compare register. On a match, the channel toggles, clears or sets its waveform bit, as its two-bit output-mode field selects.

Each channel owns one I/O pin. While the channel's output mode is zero, the pin shows a software port value. Any other mode hands the pin to the channel's waveform bit. The direction bit of the pin decides whether the pin is driven at all. Software reaches every register over a simple write/read bus with a combinational read path.

Top module: `tcu_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. Both pins show value 0 with their output enables low.
- R2: Register map, by word address:
  - 0: control. Bits 7:6 hold the A output mode, bits 5:4 the B output mode and bits 1:0 the waveform mode. All other bits read zero.
  - 1: prescaler select, bits 2:0.
  - 2: count.
  - 3: compare A.
  - 4: compare B.
  - 5: overflow flag, bit 0.
  - 6: pin direction (bit 0 is pin A, bit 1 is pin B).
  - 7: port value (bit 0 is A, bit 1 is B).
  Every field reads back what was last written to it.
- R3: Prescaler select codes:
  - 1: a tick every clock.
  - 2: a tick every 8 clocks.
  - 3: a tick every 64 clocks.
  - 4: a tick every 256 clocks.
  - 5: a tick every 1024 clocks.
  - 0, 6, 7: stopped.
  The prescaler phase is a free-running 10-bit count from reset. A tick occurs when its low 3, 6, 8 or 10 bits are all ones. The counter changes only on a tick or on a bus write, and it holds while stopped.
- R4: When the counter goes from 0xFFFF to 0 on a tick, the sticky overflow flag is set. Writing 1 to bit 0 of address 5 clears it. A set in the same cycle wins over the clear.
- R5: With waveform mode 01 (clear-on-compare), a tick taken while the counter equals compare A returns the counter to 0. Waveform modes 00, 10 and 11 count freely.
- R6: A compare match is a tick on which the counter equals the channel's compare register. The pin action takes effect at that same clock edge.
- R7: Output mode 01 inverts the channel's waveform bit on each match.
- R8: Output mode 10 forces the waveform bit to 0 on a match, and output mode 11 forces it to 1.
- R9: With output mode 00 the pin value is the port bit. With any other mode the pin value is the waveform bit. The pin output enable equals the direction bit.
- R10: A bus write to the count blocks all compare matches on the next tick. The clear-on-compare return to zero still happens on that tick.
- R11: With output mode 00, a match leaves the waveform bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 3 | Register word address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the word at bus_addr (combinational) |
| pin_out | output | 2 | Pin values, bit 0 is pin A, bit 1 is pin B |
| pin_oe | output | 2 | Pin output enables |

## Verification
If the prescaler phase is wrong, the count read back drifts from the expected value at the first tick that should or should not have happened. With select 1 that shows within one clock. With slow selects it can take up to 1024 clocks. A wrong waveform bit or a leaked blocking state shows on a pin at the clock edge of the offending match, but only while that channel's mode is nonzero. For that reason the bench switches modes and reads pins every cycle, so that a bit held while disconnected (R11) is seen when it is reconnected.

// File: rtl/tcu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the timer compare output unit.
// Assumes one word address per register on the bus.
package tcu_pkg;
    localparam int NCH = 2;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_PSEL = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;
    localparam logic [2:0] ADR_CMPA = 3'd3;
    localparam logic [2:0] ADR_FLAG = 3'd5;
    localparam logic [2:0] ADR_DIR  = 3'd6;
    localparam logic [2:0] ADR_PORT = 3'd7;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } out_mode_e;

    localparam logic [1:0] WM_CTC = 2'b01;

    typedef enum logic [2:0] {
        PS_STOP  = 3'd0,
        PS_DIV1  = 3'd1,
        PS_DIV8  = 3'd2,
        PS_DIV64 = 3'd3,
        PS_DIV256 = 3'd4,
        PS_DIV1024 = 3'd5
    } psel_e;
endpackage

// File: rtl/tcu_prescaler.sv
`timescale 1ns/1ps
// Module: tcu_prescaler
// Free-running phase counter from reset; produces a one-cycle tick for the
// selected divide ratio. Assumes PRE_W >= 10 so the slowest ratio fits.
module tcu_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    import tcu_pkg::*;

    localparam logic [PRE_W-1:0] M8    = PRE_W'((1 << 3) - 1);
    localparam logic [PRE_W-1:0] M64   = PRE_W'((1 << 6) - 1);
    localparam logic [PRE_W-1:0] M256  = PRE_W'((1 << 8) - 1);
    localparam logic [PRE_W-1:0] M1024 = PRE_W'((1 << 10) - 1);

    logic [PRE_W-1:0] phase;

    // Advance the phase counter every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Pick the tick that matches the selected ratio.
    always_comb begin
        case (sel)
            PS_DIV1:    tick = 1'b1;
            PS_DIV8:    tick = ((phase & M8) == M8);
            PS_DIV64:   tick = ((phase & M64) == M64);
            PS_DIV256:  tick = ((phase & M256) == M256);
            PS_DIV1024: tick = ((phase & M1024) == M1024);
            default:    tick = 1'b0;
        endcase
    end

    // R3: with divide-by-1, consecutive cycles always tick
    assert_div1_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PS_DIV1) |-> tick);
endmodule

// File: rtl/tcu_counter.sv
`timescale 1ns/1ps
// Module: tcu_counter
// Counter with free-running or clear-on-compare count, sticky wrap flag
// and a one-tick compare block after a bus write. Assumes tick is a
// single-cycle strobe.
module tcu_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctc,
    input  logic [CNT_W-1:0] top,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             cmp_en
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             blocked;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;

    // Next count on a tick: bottom after TOP in clear-on-compare, else +1.
    always_comb begin
        if (ctc && cnt == top) cnt_nxt = '0;
        else                   cnt_nxt = cnt + 1'b1;
    end

    // A wrap is a tick that takes the counter from all ones to zero.
    always_comb wrap = tick && !wr && (cnt == CNT_MAX);

    // Count register and the one-tick compare block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            blocked <= 1'b0;
        end else if (wr) begin
            cnt     <= wdata;
            blocked <= 1'b1;
        end else if (tick) begin
            cnt     <= cnt_nxt;
            blocked <= 1'b0;
        end
    end

    // Sticky overflow flag, set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf <= 1'b0;
        else if (wrap)     ovf <= 1'b1;
        else if (flag_clr) ovf <= 1'b0;
    end

    assign cmp_en = !blocked;

    // R3: without tick or write the count holds
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> $stable(cnt));
    // R4: wrapping tick leaves the flag set
    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && cnt == CNT_MAX) |=> (ovf && cnt == '0));
    // R5: tick at TOP in clear-on-compare returns to bottom
    assert_ctc_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && ctc && cnt == top) |=> (cnt == '0));
    // R10: a count write loads the value and blocks the next tick's match
    assert_write_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata) && !cmp_en));
endmodule

// File: rtl/tcu_cmp_channel.sv
`timescale 1ns/1ps
// Module: tcu_cmp_channel
// One compare channel: detects a match on a tick, updates its waveform bit
// per the output mode and muxes the pin between waveform and port value.
module tcu_cmp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [1:0]       mode,
    input  logic             port_val,
    input  logic             dir,
    output logic             wave,
    output logic             pin_out,
    output logic             pin_oe
);
    import tcu_pkg::*;

    logic match;
    logic wave_nxt;

    // Match only on an unblocked tick with equal values.
    always_comb match = tick && cmp_en && (cnt == cmp);

    // Waveform action chosen by the output mode.
    always_comb begin
        case (out_mode_e'(mode))
            OM_TOGGLE: wave_nxt = ~wave;
            OM_CLEAR:  wave_nxt = 1'b0;
            OM_SET:    wave_nxt = 1'b1;
            default:   wave_nxt = wave;
        endcase
    end

    // Waveform register updated on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave <= 1'b0;
        else if (match) wave <= wave_nxt;
    end

    // Pin override: any nonzero mode hands the pin to the waveform.
    always_comb pin_out = (mode != OM_OFF) ? wave : port_val;
    assign pin_oe = dir;

    // R7: toggle mode inverts on a match
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OM_TOGGLE) |=> (wave != $past(wave)));
    // R8: clear and set modes force the level
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OM_CLEAR) |=> !wave);
    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == OM_SET) |=> wave);
    // R11: disconnected mode or no match keeps the waveform
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!match || mode == OM_OFF) |=> $stable(wave));
endmodule

// File: rtl/tcu_top.sv
`timescale 1ns/1ps
// Module: tcu_top
// Timer compare output unit: register file, prescaler, counter and one
// compare channel per pin. Assumes CNT_W >= 8 so control fits the word.
module tcu_top #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [1:0]        pin_out,
    output logic [1:0]        pin_oe
);
    import tcu_pkg::*;

    localparam int PAD_W = CNT_W - 8;

    logic [1:0]       out_mode [NCH];
    logic [1:0]       wave_mode;
    logic [2:0]       psel;
    logic [CNT_W-1:0] cmp_reg  [NCH];
    logic [NCH-1:0]   dir_reg;
    logic [NCH-1:0]   port_reg;
    logic [NCH-1:0]   wave;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic             cmp_en;
    logic             cnt_wr;
    logic             flag_clr;

    // Decode the bus strobes that reach the counter.
    always_comb begin
        cnt_wr   = bus_we && (bus_addr == ADR_CNT);
        flag_clr = bus_we && (bus_addr == ADR_FLAG) && bus_wdata[0];
    end

    // Control, prescaler select, direction and port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mode[0] <= '0;
            out_mode[1] <= '0;
            wave_mode   <= '0;
            psel        <= '0;
            dir_reg     <= '0;
            port_reg    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADR_CTRL: begin
                    out_mode[0] <= bus_wdata[7:6];
                    out_mode[1] <= bus_wdata[5:4];
                    wave_mode   <= bus_wdata[1:0];
                end
                ADR_PSEL: psel     <= bus_wdata[2:0];
                ADR_DIR:  dir_reg  <= bus_wdata[NCH-1:0];
                ADR_PORT: port_reg <= bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    tcu_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (psel),
        .tick (tick)
    );

    tcu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ctc     (wave_mode == WM_CTC),
        .top     (cmp_reg[0]),
        .wr      (cnt_wr),
        .wdata   (bus_wdata),
        .flag_clr(flag_clr),
        .cnt     (cnt),
        .ovf     (ovf),
        .cmp_en  (cmp_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Compare register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) cmp_reg[i] <= '0;
            else if (bus_we && bus_addr == ADR_CMPA + 3'(i)) cmp_reg[i] <= bus_wdata;
        end

        tcu_cmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cmp_en  (cmp_en),
            .cnt     (cnt),
            .cmp     (cmp_reg[i]),
            .mode    (out_mode[i]),
            .port_val(port_reg[i]),
            .dir     (dir_reg[i]),
            .wave    (wave[i]),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i])
        );
    end

    // Combinational read mux.
    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = {{PAD_W{1'b0}}, out_mode[0], out_mode[1], 2'b00, wave_mode};
            ADR_PSEL: bus_rdata = {{(CNT_W-3){1'b0}}, psel};
            ADR_CNT:  bus_rdata = cnt;
            ADR_CMPA: bus_rdata = cmp_reg[0];
            ADR_FLAG: bus_rdata = {{(CNT_W-1){1'b0}}, ovf};
            ADR_DIR:  bus_rdata = {{(CNT_W-NCH){1'b0}}, dir_reg};
            ADR_PORT: bus_rdata = {{(CNT_W-NCH){1'b0}}, port_reg};
            default:  bus_rdata = cmp_reg[1];
        endcase
    end

    // R1: the cycle after reset all pins are released
    assert_reset_pins_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == 2'b00 && pin_out == 2'b00));
endmodule

// File: tb/tcu_top_test.sv
`timescale 1ns/1ps
module tcu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  pin_out, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tcu_top uut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Reference state built from the requirements
    int          m_pre;
    logic [15:0] m_cnt, m_cmpa, m_cmpb;
    logic [1:0]  m_ma, m_mb, m_wm, m_dir, m_port, m_wave;
    logic [2:0]  m_sel;
    logic        m_ovf, m_blk;

    function automatic bit f_tick(logic [2:0] s, int p);
        case (s)
            3'd1: return 1'b1;
            3'd2: return (p % 8) == 7;
            3'd3: return (p % 64) == 63;
            3'd4: return (p % 256) == 255;
            3'd5: return (p % 1024) == 1023;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic f_act(logic [1:0] md, logic w);
        case (md)
            2'b01: return ~w;
            2'b10: return 1'b0;
            2'b11: return 1'b1;
            default: return w;
        endcase
    endfunction

    function automatic logic [15:0] f_read(logic [2:0] a);
        case (a)
            3'd0: return {8'h00, m_ma, m_mb, 2'b00, m_wm};
            3'd1: return {13'd0, m_sel};
            3'd2: return m_cnt;
            3'd3: return m_cmpa;
            3'd4: return m_cmpb;
            3'd5: return {15'd0, m_ovf};
            3'd6: return {14'd0, m_dir};
            default: return {14'd0, m_port};
        endcase
    endfunction

    function automatic logic [1:0] f_pins();
        logic [1:0] p;
        p[0] = (m_ma != 2'b00) ? m_wave[0] : m_port[0];
        p[1] = (m_mb != 2'b00) ? m_wave[1] : m_port[1];
        return p;
    endfunction

    // Model update at each edge with the inputs held since the last negedge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_ma = 0; m_mb = 0;
            m_wm = 0; m_dir = 0; m_port = 0; m_wave = 0; m_sel = 0;
            m_ovf = 0; m_blk = 0;
        end else begin
            automatic bit tk = f_tick(m_sel, m_pre);
            automatic bit cw = we && addr == 3'd2;
            automatic bit wrap = 0;
            m_pre = (m_pre + 1) % 1024;
            if (tk && !m_blk) begin
                if (m_cnt == m_cmpa) m_wave[0] = f_act(m_ma, m_wave[0]);
                if (m_cnt == m_cmpb) m_wave[1] = f_act(m_mb, m_wave[1]);
            end
            if (cw) begin
                m_cnt = wdata; m_blk = 1;
            end else if (tk) begin
                m_blk = 0;
                if (m_wm == 2'b01 && m_cnt == m_cmpa) m_cnt = 0;
                else begin
                    wrap = (m_cnt == 16'hFFFF);
                    m_cnt = m_cnt + 16'd1;
                end
            end
            if (wrap) m_ovf = 1;
            else if (we && addr == 3'd5 && wdata[0]) m_ovf = 0;
            if (we) case (addr)
                3'd0: begin m_ma = wdata[7:6]; m_mb = wdata[5:4]; m_wm = wdata[1:0]; end
                3'd1: m_sel = wdata[2:0];
                3'd3: m_cmpa = wdata;
                3'd4: m_cmpb = wdata;
                3'd6: m_dir = wdata[1:0];
                3'd7: m_port = wdata[1:0];
                default: ;
            endcase
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One bus cycle: check pins, drive inputs, check the read word
    task automatic cyc(bit w, logic [2:0] a, logic [15:0] d, string tag);
        @(negedge clk);
        chk({tag, " R6 R9 pin value"}, {14'd0, pin_out}, {14'd0, f_pins()});
        chk({tag, " R9 pin enable"}, {14'd0, pin_oe}, {14'd0, m_dir});
        we = w; addr = a; wdata = d;
        #1;
        chk({tag, " read"}, rdata, f_read(a));
    endtask

    task automatic idle(int n, logic [2:0] a, string tag);
        for (int k = 0; k < n; k++) cyc(0, a, 16'd0, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register
        for (int a = 0; a < 8; a++) cyc(0, 3'(a), 16'd0, "R1 reset");
        // R2: control readback masks unused bits
        cyc(1, 3'd0, 16'hFFFF, "R2 ctrl write");
        cyc(0, 3'd0, 16'd0, "R2 ctrl readback");
        cyc(1, 3'd0, 16'h0000, "R2 ctrl clear");
        cyc(1, 3'd3, 16'h1234, "R2 cmpA");
        cyc(1, 3'd4, 16'hBEEF, "R2 cmpB");
        idle(1, 3'd4, "R2 cmpB readback");
        // R3: divide by 8 then stop
        cyc(1, 3'd1, 16'd2, "R3 sel8");
        idle(40, 3'd2, "R3 div8 count");
        cyc(1, 3'd1, 16'd3, "R3 sel64");
        idle(150, 3'd2, "R3 div64 count");
        cyc(1, 3'd1, 16'd0, "R3 stop");
        idle(20, 3'd2, "R3 stopped holds");
        // R4: wrap sets flag, write one clears
        cyc(1, 3'd2, 16'hFFFD, "R4 near max");
        cyc(1, 3'd1, 16'd1, "R4 sel1");
        idle(6, 3'd5, "R4 flag set");
        cyc(1, 3'd5, 16'd1, "R4 flag clear");
        idle(2, 3'd5, "R4 flag cleared");
        // R5, R7: clear-on-compare with toggle on A, set on B
        cyc(1, 3'd3, 16'd5, "R5 top");
        cyc(1, 3'd4, 16'd2, "R8 cmpB");
        cyc(1, 3'd6, 16'd3, "R9 dir");
        cyc(1, 3'd0, 16'h0071, "R7 toggle A set B ctc");
        idle(20, 3'd2, "R5 ctc count");
        // R8: B clear
        cyc(1, 3'd0, 16'h0061, "R8 clear B");
        idle(10, 3'd2, "R8 clear B run");
        // R10: write count equal to TOP blocks the match
        cyc(1, 3'd2, 16'd5, "R10 write at top");
        idle(3, 3'd2, "R10 blocked tick");
        // R11: disconnected A sees matches but keeps its level
        cyc(1, 3'd7, 16'd2, "R9 port");
        cyc(1, 3'd0, 16'h0001, "R11 A off");
        idle(13, 3'd2, "R11 A off run");
        cyc(1, 3'd0, 16'h0041, "R11 A reconnect");
        idle(2, 3'd2, "R11 A held level");
        // Random mix
        for (int i = 0; i < 6000; i++) begin
            automatic int r = $urandom % 100;
            automatic logic [2:0] ra = 3'($urandom % 8);
            if (r < 70) cyc(0, ra, 16'd0, "rand R3 R6");
            else if (r < 76) cyc(1, 3'd2, ($urandom % 2) ? 16'($urandom % 48) : 16'hFFF0 + 16'($urandom % 16), "rand R10");
            else if (r < 82) cyc(1, 3'd3, 16'($urandom % 48), "rand R5");
            else if (r < 86) cyc(1, 3'd4, 16'($urandom % 48), "rand R6");
            else if (r < 90) cyc(1, 3'd0, 16'($urandom), "rand R7 R8 R11");
            else if (r < 93) cyc(1, 3'd1, 16'($urandom % 4), "rand R3");
            else if (r < 96) cyc(1, ($urandom % 2) ? 3'd6 : 3'd7, 16'($urandom), "rand R9");
            else cyc(1, 3'd5, 16'd1, "rand R4");
        end
        idle(2, 3'd2, "final");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule